// File: doc/BRIEF.md
# Saturating Charge-Cycle Counter with Near-Full Hysteresis

This block keeps a count of qualified charge events for a battery fuel gauge. A single-cycle strobe reports each valid charge. The block also receives the present nominal available charge and the learned full capacity. Each accepted strobe adds one to a saturating count. After enough events have gone by without a capacity relearn, a sticky capacity-inaccurate flag rises. This tells the host that the learned capacity may no longer be trusted.

A battery held on trickle charge near full would report many small charges as its charge drifts down by self-discharge and is topped back up. To keep these from inflating the count, a hysteresis window applies. Once a charge has been counted while the available charge is above 94 % of capacity, later charges are ignored until the available charge has dropped below that level. A single-cycle relearn strobe marks a new capacity value. It clears the count and the flag.

Top module: `charge_cycle_counter`

## Requirements
- R1: Each accepted valid-charge strobe raises `cycle_cnt_o` by exactly one, visible in the cycle after the strobe.
- R2: The level is "high" when NAC*100 > LMD*94 and "low" when NAC*100 < LMD*94. A strobe taken while high arms a hold. While the hold is armed and the level is high, strobes are not counted. A low level disarms the hold.
- R3: The count saturates at 2^CNT_W-1 (255 by default) and never wraps to zero.
- R4: `cap_inacc_o` rises in the same cycle that the count becomes FLAG_AT (64 by default), and not before.
- R5: A relearn strobe sets the count to zero and clears the flag in the following cycle.
- R6: When a relearn strobe and a valid-charge strobe arrive together, the relearn wins. The count becomes zero and the charge does not arm the hold.
- R7: When NAC*100 equals LMD*94 exactly, the hold keeps its previous state.
- R8: Once set, the flag stays set at every count above FLAG_AT, including saturation, until a relearn strobe.
- R9: A synchronous active-low reset clears the count, the flag and the hold.
- R10: Without a valid-charge or relearn strobe, the count and flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chg_valid_i | input | 1 | Single-cycle strobe marking one qualified charge |
| nac_i | input | Q_W | Present nominal available charge |
| lmd_i | input | Q_W | Learned full capacity |
| lmd_upd_i | input | 1 | Single-cycle strobe marking a capacity relearn |
| cycle_cnt_o | output | CNT_W | Saturating charge-event count |
| cap_inacc_o | output | 1 | Capacity-inaccurate flag |

## Verification
The bench builds the block with CNT_W=5, FLAG_AT=12 and Q_W=6. With 6-bit charge inputs, all 4096 NAC/LMD pairs can be swept through the threshold comparison. Each pair is swept with the hold cleared, then followed by a relearn and two strobes. With a 5-bit count, the flag point and saturation at 31 are reached in a few dozen strobes. This leaves room to check the exact-equality pair (47, 50), combined relearn-and-charge cycles, and a reset taken while the hold is armed.

// File: rtl/ccc_pkg.sv
package ccc_pkg;

  // Fixed-point ratio used for the near-full threshold: level = lmd * NUM / DEN
  localparam int unsigned FULL_NUM = 94;
  localparam int unsigned FULL_DEN = 100;

  // True when nac lies strictly above the scaled capacity
  function automatic logic lvl_above(input logic [63:0] nac, input logic [63:0] lmd);
    return (nac * 64'(FULL_DEN)) > (lmd * 64'(FULL_NUM));
  endfunction

  // True when nac lies strictly below the scaled capacity
  function automatic logic lvl_below(input logic [63:0] nac, input logic [63:0] lmd);
    return (nac * 64'(FULL_DEN)) < (lmd * 64'(FULL_NUM));
  endfunction

endpackage

// File: rtl/ccc_level_cmp.sv
module ccc_level_cmp #(
  parameter int Q_W = 16
) (
  input  logic [Q_W-1:0] nac_i,
  input  logic [Q_W-1:0] lmd_i,
  output logic           above_o,
  output logic           below_o
);
  import ccc_pkg::*;

  always_comb begin
    above_o = lvl_above(64'(nac_i), 64'(lmd_i));
    below_o = lvl_below(64'(nac_i), 64'(lmd_i));
  end

  // Above and below are mutually exclusive
  always_comb begin
    a_excl_r2: assert (!(above_o && below_o));
  end

endmodule

// File: rtl/ccc_repeat_gate.sv
module ccc_repeat_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_valid_i,
  input  logic lmd_upd_i,
  input  logic above_i,
  input  logic below_i,
  output logic taken_o,
  output logic hold_o
);

  logic hold_q;
  logic blocked;

  assign blocked = above_i && hold_q;
  // A relearn in the same cycle pre-empts the charge (R6)
  assign taken_o = chg_valid_i && !lmd_upd_i && !blocked;
  assign hold_o  = hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
    end else if (below_i) begin
      hold_q <= 1'b0;
    end else if (taken_o && above_i) begin
      hold_q <= 1'b1;
    end
  end

  // Hold armed and level high means no count may be taken
  p_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && above_i) |-> !taken_o);

  // A low level always disarms the hold
  p_disarm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    below_i |=> !hold_q);

  // At exact equality the hold keeps its state
  p_equal_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!above_i && !below_i) |=> (hold_q == $past(hold_q)));

  // Relearn plus charge never arms the hold
  p_upd_no_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lmd_upd_i && !hold_q) |=> !hold_q);

endmodule

// File: rtl/ccc_sat_counter.sv
module ccc_sat_counter #(
  parameter int CNT_W   = 8,
  parameter int FLAG_AT = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             taken_i,
  input  logic             lmd_upd_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             flag_o
);

  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] FLAG_V   = CNT_W'(FLAG_AT);
  localparam logic [CNT_W-1:0] PRE_FLAG = CNT_W'(FLAG_AT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             flag_q;
  logic             at_max;
  logic             bump;

  assign at_max = (cnt_q == CNT_MAX);
  assign bump   = taken_i && !at_max;
  assign cnt_o  = cnt_q;
  assign flag_o = flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (lmd_upd_i) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (bump) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == PRE_FLAG) flag_q <= 1'b1;
    end
  end

  p_step_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (taken_i && !lmd_upd_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  p_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !lmd_upd_i) |=> (cnt_q == CNT_MAX));

  p_flag_at_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FLAG_V) |-> flag_q);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lmd_upd_i |=> (cnt_q == '0 && !flag_q));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !lmd_upd_i) |=> flag_q);

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!taken_i && !lmd_upd_i) |=> ($stable(cnt_q) && $stable(flag_q)));

endmodule

// File: rtl/charge_cycle_counter.sv
module charge_cycle_counter #(
  parameter int CNT_W   = 8,
  parameter int FLAG_AT = 64,
  parameter int Q_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_valid_i,
  input  logic [Q_W-1:0]   nac_i,
  input  logic [Q_W-1:0]   lmd_i,
  input  logic             lmd_upd_i,
  output logic [CNT_W-1:0] cycle_cnt_o,
  output logic             cap_inacc_o
);

  logic above;
  logic below;
  logic taken;
  logic hold;

  ccc_level_cmp #(.Q_W(Q_W)) cmp_i (
    .nac_i   (nac_i),
    .lmd_i   (lmd_i),
    .above_o (above),
    .below_o (below)
  );

  ccc_repeat_gate gate_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_valid_i (chg_valid_i),
    .lmd_upd_i   (lmd_upd_i),
    .above_i     (above),
    .below_i     (below),
    .taken_o     (taken),
    .hold_o      (hold)
  );

  ccc_sat_counter #(.CNT_W(CNT_W), .FLAG_AT(FLAG_AT)) ctr_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .taken_i   (taken),
    .lmd_upd_i (lmd_upd_i),
    .cnt_o     (cycle_cnt_o),
    .flag_o    (cap_inacc_o)
  );

  // Reset leaves count, flag and hold cleared
  p_reset_r9: assert property (@(posedge clk)
    !rst_n |=> (cycle_cnt_o == '0 && !cap_inacc_o && !hold));

endmodule

// File: tb/charge_cycle_counter_tb_top.sv
`timescale 1ns/1ps
module charge_cycle_counter_tb_top;

  localparam int CNT_W   = 5;
  localparam int FLAG_AT = 12;
  localparam int Q_W     = 6;
  localparam int SAT     = (1 << CNT_W) - 1;
  localparam int QMAX    = (1 << Q_W) - 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             chg = 1'b0;
  logic             upd = 1'b0;
  logic [Q_W-1:0]   nac = '0;
  logic [Q_W-1:0]   lmd = '0;
  logic [CNT_W-1:0] cnt;
  logic             flag;

  int total = 0;
  int fails = 0;
  int m_cnt = 0;
  bit m_flag = 0;
  bit m_hold = 0;

  always #4 clk = ~clk;

  charge_cycle_counter #(.CNT_W(CNT_W), .FLAG_AT(FLAG_AT), .Q_W(Q_W)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .chg_valid_i (chg),
    .nac_i       (nac),
    .lmd_i       (lmd),
    .lmd_upd_i   (upd),
    .cycle_cnt_o (cnt),
    .cap_inacc_o (flag)
  );

  // 94/100 restated as 47/50
  function automatic bit hi(int n, int l);
    return n * 50 > l * 47;
  endfunction
  function automatic bit lo(int n, int l);
    return n * 50 < l * 47;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(bit c, bit u, int n, int l, string tag);
    bit tk;
    chg = c; upd = u; nac = Q_W'(n); lmd = Q_W'(l);
    @(posedge clk);
    tk = c && !u && !(hi(n, l) && m_hold);
    if (u) begin
      m_cnt = 0; m_flag = 0;
    end else if (tk && m_cnt < SAT) begin
      m_cnt++;
      if (m_cnt == FLAG_AT) m_flag = 1;
    end
    if (lo(n, l)) m_hold = 0;
    else if (tk && hi(n, l)) m_hold = 1;
    #1 chg = 1'b0; upd = 1'b0;
    @(negedge clk);
    chk(int'(cnt) == m_cnt, tag, int'(cnt), m_cnt);
    chk(flag == m_flag, {tag, " flag"}, int'(flag), int'(m_flag));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    #1 rst_n = 1'b1;
    m_cnt = 0; m_flag = 0; m_hold = 0;
    @(negedge clk);
  endtask

  initial begin
    #1500000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    do_reset();
    // R9: reset state
    chk(cnt == '0, "R9 reset count", int'(cnt), 0);
    chk(flag == 1'b0, "R9 reset flag", int'(flag), 0);

    // R1 / R10: low level counting, idles in between
    step(1, 0, 0, 10, "R1 first");
    chk(int'(cnt) == 1, "R1 one", int'(cnt), 1);
    step(0, 0, 0, 10, "R10 idle");
    step(0, 0, 63, 10, "R10 idle high");
    chk(int'(cnt) == 1, "R10 unchanged", int'(cnt), 1);

    // R4: flag exactly at FLAG_AT
    for (int i = 2; i < FLAG_AT; i++) step(1, 0, 0, 10, "R1 climb");
    chk(int'(cnt) == FLAG_AT - 1 && !flag, "R4 before flag", int'(flag), 0);
    step(1, 0, 0, 10, "R4 reach");
    chk(int'(cnt) == FLAG_AT && flag, "R4 flag at threshold", int'(flag), 1);

    // R3 / R8: saturate and keep flag
    for (int i = 0; i < SAT; i++) step(1, 0, 0, 10, "R3 climb");
    chk(int'(cnt) == SAT, "R3 saturated", int'(cnt), SAT);
    chk(flag == 1'b1, "R8 flag at saturation", int'(flag), 1);
    step(0, 0, 0, 10, "R8 idle");

    // R5: relearn clears
    step(0, 1, 0, 10, "R5 relearn");
    chk(cnt == '0 && !flag, "R5 cleared", int'(cnt), 0);

    // R6: relearn beats charge; hold not armed
    step(1, 1, 63, 10, "R6 both");
    chk(cnt == '0, "R6 reset wins", int'(cnt), 0);
    step(1, 0, 63, 10, "R6 hold unarmed");
    chk(int'(cnt) == 1, "R6 counted after", int'(cnt), 1);
    step(1, 0, 63, 10, "R2 blocked");
    chk(int'(cnt) == 1, "R2 second high blocked", int'(cnt), 1);

    // R7: equality (47*50 == 50*47) keeps hold armed, still counts (not high)
    step(1, 0, 47, 50, "R7 equal count");
    chk(int'(cnt) == 2, "R7 equal counts", int'(cnt), 2);
    step(1, 0, 63, 50, "R7 back high");
    chk(int'(cnt) == 2, "R7 hold kept", int'(cnt), 2);
    step(0, 0, 0, 50, "R2 drop low");
    step(1, 0, 63, 50, "R2 rearmed");
    chk(int'(cnt) == 3, "R2 count after low", int'(cnt), 3);

    // R9: mid-run reset clears the armed hold
    do_reset();
    chk(cnt == '0 && !flag, "R9 mid reset", int'(cnt), 0);
    step(1, 0, 63, 50, "R9 hold cleared");
    chk(int'(cnt) == 1, "R9 high count after reset", int'(cnt), 1);

    // R2: exhaustive threshold sweep
    for (int n = 0; n <= QMAX; n++) begin
      for (int l = 0; l <= QMAX; l++) begin
        step(0, 0, 0, 1, "R2 sweep clear");
        step(0, 1, n, l, "R5 sweep relearn");
        step(1, 0, n, l, "R2 sweep first");
        step(1, 0, n, l, "R2 sweep second");
        chk(int'(cnt) == (hi(n, l) ? 1 : 2), "R2 sweep pair",
            int'(cnt), hi(n, l) ? 1 : 2);
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule